// File: doc/BRIEF.md
# Address-Sequence Unlock Detector

This block watches the control strobes and address lines of an asynchronous SRAM bus and turns one special series of ordinary reads into a command. Six reads must arrive back to back, the first five at fixed addresses in a fixed order. The sixth address then selects the command. One value raises a single-cycle store request and another raises a single-cycle recall request. Any write, any read that is out of order, and any reserved final address throws the series away without a request.

Each bus access is taken once, on the falling edge of the active-low chip enable. The strobes and address are first passed through a synchroniser chain into the system clock. Falling edges are then found in that clock domain. Only the low fourteen address bits take part in matching, so the top address bit of the bus is not wired to the block. Output enable plays no part in the decision and is not an input. A busy input from the nonvolatile copy engine blocks detection while that engine runs and sends the detector back to its idle position.

Top module: `seq_unlock_detector`

## Requirements
- R1: While reset is high and on the first cycle after it, `store_req` and `recall_req` are 0 and `seq_pos` is 0.
- R2: `seq_pos` holds the number of pattern reads matched so far, 0 to 5. The pattern reads on `addr_lo` are 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, and they must come in this order.
- R3: A read of 0x0FC0 while `seq_pos` is 5 raises `store_req` for exactly one cycle and returns `seq_pos` to 0.
- R4: A read of 0x0C63 while `seq_pos` is 5 raises `recall_req` for exactly one cycle and returns `seq_pos` to 0. The two requests are never high together.
- R5: An access is a write when `we_n` is 0 at the chip-enable fall. A write at any position sets `seq_pos` to 0 and raises no request.
- R6: A read that is not the next expected address sets `seq_pos` to 0. If that read is 0x0E38, `seq_pos` becomes 1 instead.
- R7: A read of 0x339C while `seq_pos` is 5 raises neither request and sets `seq_pos` to 0.
- R8: A second chip-enable pulse at the address just matched counts as a new, out-of-order read and breaks the series.
- R9: While `busy` is 1, accesses are ignored, no request is raised and `seq_pos` is 0 on the next cycle.
- R10: Only a 1-to-0 change of `ce_n` makes an access. Suppose `ce_n` is first sampled low at rising edge k, after being sampled high at edge k-1. The resulting change on the outputs then appears just after edge k+3. Holding `ce_n` low longer makes no further access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| busy | input | 1 | Nonvolatile copy in progress; blocks detection |
| ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| we_n | input | 1 | Bus write enable, active low, asynchronous |
| addr_lo | input | 14 | Low address bits of the bus, asynchronous |
| store_req | output | 1 | One-cycle store command |
| recall_req | output | 1 | One-cycle recall command |
| seq_pos | output | 3 | Number of pattern reads matched so far |

## Verification
The outputs answer an access just after the third rising edge that follows the first edge at which chip enable is seen low. Two synchroniser flops, the edge capture and the sequence register account for that delay. `busy` acts on the very next edge. The bench keeps a queue of the sampled inputs and reads the access from the entries three and four edges back. It then advances its own position count and compares all three outputs a quarter period after every rising edge. A separate timed check counts the edges from the enable fall to the store pulse.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    localparam int CMP_W   = 14;
    localparam int STEPS   = 5;
    localparam int POS_W   = 3;

    localparam logic [CMP_W-1:0] CODE_STORE    = 14'h0FC0;
    localparam logic [CMP_W-1:0] CODE_RECALL   = 14'h0C63;

    typedef enum logic [POS_W-1:0] {
        POS_IDLE = 3'd0,
        POS_ONE  = 3'd1,
        POS_TWO  = 3'd2,
        POS_THR  = 3'd3,
        POS_FOUR = 3'd4,
        POS_FIVE = 3'd5
    } seq_pos_e;

    typedef struct packed {
        logic             wr;
        logic [CMP_W-1:0] addr;
    } bus_access_t;

    // Address expected when the given count of pattern reads is already held.
    function automatic logic [CMP_W-1:0] pattern_code(input logic [POS_W-1:0] idx);
        logic [CMP_W-1:0] c;
        case (idx)
            3'd0:    c = 14'h0E38;
            3'd1:    c = 14'h31C7;
            3'd2:    c = 14'h03E0;
            3'd3:    c = 14'h3C1F;
            3'd4:    c = 14'h303F;
            default: c = 14'h0E38;
        endcase
        return c;
    endfunction

    function automatic seq_pos_e after_miss(input logic [CMP_W-1:0] a);
        return (a == pattern_code(3'd0)) ? POS_ONE : POS_IDLE;
    endfunction

endpackage

// File: rtl/ulk_sync.sv
module ulk_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= RST_VAL;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ulk_access_capture.sv
module ulk_access_capture
    import unlock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_s,
    input  logic             we_s,
    input  logic [CMP_W-1:0] addr_s,
    output logic             acc_valid,
    output bus_access_t      acc
);
    logic ce_prev;
    logic ce_fall;

    assign ce_fall = ce_prev & ~ce_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_prev   <= 1'b1;
            acc_valid <= 1'b0;
            acc       <= '0;
        end else begin
            ce_prev   <= ce_s;
            acc_valid <= ce_fall;
            if (ce_fall) begin
                acc.wr   <= ~we_s;
                acc.addr <= addr_s;
            end
        end
    end
endmodule

// File: rtl/ulk_sequence_fsm.sv
module ulk_sequence_fsm
    import unlock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        busy,
    input  logic        acc_valid,
    input  bus_access_t acc,
    output logic        store_req,
    output logic        recall_req,
    output seq_pos_e    pos
);
    seq_pos_e pos_nx;
    logic     store_nx;
    logic     recall_nx;

    always_comb begin
        pos_nx    = pos;
        store_nx  = 1'b0;
        recall_nx = 1'b0;
        if (busy) begin
            pos_nx = POS_IDLE;
        end else if (acc_valid) begin
            if (acc.wr) begin
                pos_nx = POS_IDLE;
            end else if (pos == POS_FIVE) begin
                if (acc.addr == CODE_STORE) begin
                    store_nx = 1'b1;
                    pos_nx   = POS_IDLE;
                end else if (acc.addr == CODE_RECALL) begin
                    recall_nx = 1'b1;
                    pos_nx    = POS_IDLE;
                end else begin
                    pos_nx = after_miss(acc.addr);
                end
            end else if (acc.addr == pattern_code(pos)) begin
                pos_nx = seq_pos_e'(pos + 3'd1);
            end else begin
                pos_nx = after_miss(acc.addr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos        <= POS_IDLE;
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            pos        <= pos_nx;
            store_req  <= store_nx;
            recall_req <= recall_nx;
        end
    end
endmodule

// File: rtl/seq_unlock_detector.sv
module seq_unlock_detector
    import unlock_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic [CMP_W-1:0] addr_lo,
    output logic             store_req,
    output logic             recall_req,
    output logic [POS_W-1:0] seq_pos
);
    localparam int BUS_W = CMP_W + 2;

    logic [BUS_W-1:0] bus_raw;
    logic [BUS_W-1:0] bus_s;
    logic             acc_valid;
    bus_access_t      acc;
    seq_pos_e         pos;

    assign bus_raw = {ce_n, we_n, addr_lo};

    ulk_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({2'b11, {CMP_W{1'b0}}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_raw),
        .q   (bus_s)
    );

    ulk_access_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .ce_s      (bus_s[BUS_W-1]),
        .we_s      (bus_s[BUS_W-2]),
        .addr_s    (bus_s[CMP_W-1:0]),
        .acc_valid (acc_valid),
        .acc       (acc)
    );

    ulk_sequence_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .acc_valid  (acc_valid),
        .acc        (acc),
        .store_req  (store_req),
        .recall_req (recall_req),
        .pos        (pos)
    );

    assign seq_pos = pos;
endmodule

// File: rtl/ulk_checker.sv
module ulk_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       store_req,
    input logic       recall_req,
    input logic [2:0] seq_pos
);
    assert_pos_range_R2: assert property (@(posedge clk) disable iff (rst)
        seq_pos <= 3'd5);

    assert_pos_step_R2: assert property (@(posedge clk) disable iff (rst)
        (seq_pos != $past(seq_pos)) |-> (seq_pos == $past(seq_pos) + 3'd1 || seq_pos <= 3'd1));

    assert_store_from_five_R3: assert property (@(posedge clk) disable iff (rst)
        store_req |-> ($past(seq_pos) == 3'd5 && seq_pos == 3'd0));

    assert_store_single_R3: assert property (@(posedge clk) disable iff (rst)
        store_req |=> !store_req);

    assert_recall_from_five_R4: assert property (@(posedge clk) disable iff (rst)
        recall_req |-> ($past(seq_pos) == 3'd5 && seq_pos == 3'd0));

    assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_req, recall_req}));

    assert_busy_idle_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (seq_pos == 3'd0 && !store_req && !recall_req));
endmodule

bind seq_unlock_detector ulk_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .store_req  (store_req),
    .recall_req (recall_req),
    .seq_pos    (seq_pos)
);

// File: tb/tb_seq_unlock_detector.sv
module tb_seq_unlock_detector;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        busy = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [13:0] addr_lo = '0;
    logic        store_req, recall_req;
    logic [2:0]  seq_pos;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    always #(PERIOD/2) clk = ~clk;

    seq_unlock_detector dut (
        .clk(clk), .rst(rst), .busy(busy), .ce_n(ce_n), .we_n(we_n),
        .addr_lo(addr_lo), .store_req(store_req), .recall_req(recall_req),
        .seq_pos(seq_pos)
    );

    // Behavioural reference
    typedef struct { bit ce; bit we; logic [13:0] a; } smp_t;
    smp_t hist[$];
    int   m_pos = 0;
    bit   m_store = 0, m_recall = 0;
    int   pat[5] = '{'h0E38, 'h31C7, 'h03E0, 'h3C1F, 'h303F};

    always @(posedge clk) begin : model
        smp_t s;
        int   a;
        s.ce = ce_n; s.we = we_n; s.a = addr_lo;
        hist.push_front(s);
        if (hist.size() > 6) void'(hist.pop_back());
        m_store = 0; m_recall = 0;
        if (rst || busy) begin
            m_pos = 0;
        end else if (hist.size() >= 5 && hist[4].ce && !hist[3].ce) begin
            a = int'(hist[3].a);
            if (!hist[3].we) m_pos = 0;
            else if (m_pos == 5) begin
                if (a == 'h0FC0)      begin m_store = 1;  m_pos = 0; end
                else if (a == 'h0C63) begin m_recall = 1; m_pos = 0; end
                else m_pos = (a == pat[0]) ? 1 : 0;
            end else if (a == pat[m_pos]) m_pos = m_pos + 1;
            else m_pos = (a == pat[0]) ? 1 : 0;
        end
    end

    int n_store = 0, n_recall = 0;
    always @(posedge clk) begin
        #(PERIOD/4);
        n_cmp++;
        if (store_req !== m_store || recall_req !== m_recall || int'(seq_pos) != m_pos) begin
            n_bad++;
            $display("FAIL %s: actual store=%0b recall=%0b pos=%0d expected store=%0b recall=%0b pos=%0d",
                     tag, store_req, recall_req, seq_pos, m_store, m_recall, m_pos);
        end
        if (store_req === 1'b1)  n_store++;
        if (recall_req === 1'b1) n_recall++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input logic [13:0] a, input bit wr, input int low_cycles = 2);
        @(negedge clk);
        ce_n = 1'b0; we_n = ~wr; addr_lo = a;
        repeat (low_cycles) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic prefix();
        for (int i = 0; i < 5; i++) access(pat[i][13:0], 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL R10 watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int edges;
        repeat (5) @(negedge clk);
        tag = "R1";
        check("R1 pos in reset", int'(seq_pos), 0);
        check("R1 store in reset", int'(store_req), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pos after reset", int'(seq_pos), 0);

        // R2 and R3: full store pattern, position steps visible
        tag = "R2";
        for (int i = 0; i < 5; i++) begin
            access(pat[i][13:0], 0);
            settle();
            check("R2 position count", int'(seq_pos), i + 1);
        end
        tag = "R3";
        n_store = 0;
        access(14'h0FC0, 0); settle();
        check("R3 one store pulse", n_store, 1);
        check("R3 pos back to 0", int'(seq_pos), 0);

        // R4: recall pattern
        tag = "R4";
        n_recall = 0; n_store = 0;
        prefix(); access(14'h0C63, 0); settle();
        check("R4 one recall pulse", n_recall, 1);
        check("R4 no store", n_store, 0);

        // R5: write in the middle
        tag = "R5";
        access(pat[0][13:0], 0); access(pat[1][13:0], 0);
        access(pat[2][13:0], 1); settle();
        check("R5 write aborts", int'(seq_pos), 0);
        n_store = 0;
        access(pat[3][13:0], 0); access(pat[4][13:0], 0); access(14'h0FC0, 0); settle();
        check("R5 no store after abort", n_store, 0);
        // write at the first pattern address does not start the series
        access(pat[0][13:0], 1); settle();
        check("R5 write of first code", int'(seq_pos), 0);

        // R6: wrong address, then restart through first code
        tag = "R6";
        access(pat[0][13:0], 0); access(pat[1][13:0], 0); access(14'h1234, 0); settle();
        check("R6 wrong read aborts", int'(seq_pos), 0);
        access(pat[0][13:0], 0); access(pat[1][13:0], 0); access(pat[0][13:0], 0); settle();
        check("R6 restart at first code", int'(seq_pos), 1);
        n_store = 0;
        for (int i = 1; i < 5; i++) access(pat[i][13:0], 0);
        access(14'h0FC0, 0); settle();
        check("R6 store after restart", n_store, 1);

        // R7: reserved final address
        tag = "R7";
        n_store = 0; n_recall = 0;
        prefix(); access(14'h339C, 0); settle();
        check("R7 reserved no store", n_store, 0);
        check("R7 reserved no recall", n_recall, 0);
        check("R7 pos idle", int'(seq_pos), 0);

        // R8: duplicate pulse at same address
        tag = "R8";
        access(pat[0][13:0], 0); access(pat[1][13:0], 0); access(pat[1][13:0], 0); settle();
        check("R8 duplicate breaks", int'(seq_pos), 0);

        // R9: busy mid-series
        tag = "R9";
        access(pat[0][13:0], 0); access(pat[1][13:0], 0); access(pat[2][13:0], 0); settle();
        @(negedge clk) busy = 1'b1;
        @(negedge clk);
        check("R9 busy clears pos", int'(seq_pos), 0);
        access(pat[3][13:0], 0); settle();
        check("R9 access ignored while busy", int'(seq_pos), 0);
        @(negedge clk) busy = 1'b0;
        n_store = 0;
        access(pat[4][13:0], 0); access(14'h0FC0, 0); settle();
        check("R9 no store after busy", n_store, 0);

        // R10: latency and long low pulse
        tag = "R10";
        prefix();
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; addr_lo = 14'h0FC0;
        edges = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); edges++;
            #(PERIOD/4);
            if (store_req === 1'b1) break;
        end
        check("R10 edges to store", edges, 4);
        repeat (6) @(negedge clk);
        check("R10 held low no extra access", int'(seq_pos), 0);
        ce_n = 1'b1;
        settle();
        prefix();
        @(negedge clk); ce_n = 1'b0; addr_lo = 14'h0E38;
        repeat (8) @(negedge clk);
        check("R10 long low counts once", int'(seq_pos), 1);
        ce_n = 1'b1;
        settle();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule